// File: doc/BRIEF.md
# SDRAM Power-Down Sequencer

This block sits inside an SDRAM controller and owns the clock-enable pin. When the controller asks it to sleep, it confirms that every bank is closed and that the row-precharge time has run out since the last precharge. Only then does it drop CKE. While CKE is low, and through the wake-up delay that follows, it holds the command bus at NOP. It brings CKE back up when the sleep request is withdrawn or when a refresh falls due. It also forces a wake-up before a maximum dwell count runs out, because the device does no refreshing while it is powered down.

The block has no data path, so it has no valid/ready stream. Every pin is a plain level or pulse. The controller reports each precharge it issues as a one-cycle pulse on `pre_issued`, and supplies the precharge time as a programmable count. A wake-up caused by a refresh or by the dwell limit raises `ref_req` toward the refresh engine. That request stays up until the engine pulses `ref_ack`, and while it is pending the block will not enter power-down again. `ready` marks the cycles in which the controller may place a real command on the bus.

Top module: `sdram_pd_ctrl`

## Requirements
- R1: During and after reset, `cke`=1, `cmd_nop`=0, `ready`=1 and `ref_req`=0. Reset is asynchronous and active low.
- R2: While any bit of `bank_open` is 1, `cke` stays 1 regardless of `sleep_req`.
- R3: A `pre_issued` pulse sampled at edge p with `trp_cycles`=N (N≥1) keeps `cke` high until edge p+N. At edge p+N, with all other entry conditions met, `cke` falls. With N=0, `cke` falls at edge p+1.
- R4: With all entry conditions met at a clock edge, `cke` goes to 0 after that edge. In the same cycle `cmd_nop` goes to 1 and `ready` goes to 0.
- R5: Once `cke` falls, it stays low for at least two cycles, even if `sleep_req` is withdrawn at once.
- R6: When power-down ends, `cke` rises and `cmd_nop` stays 1 for that cycle and the next. After those two cycles `ready`=1 and `cmd_nop`=0.
- R7: `cke` is never low for more than MAX_DWELL consecutive cycles. When `sleep_req` is held, it is low for exactly MAX_DWELL cycles, then rises with `ref_req` set.
- R8: A `refresh_due` sampled high while powered down makes `cke` rise at the next edge, and `ref_req` rises at the same edge.
- R9: `ref_req` stays 1 until an edge that samples `ref_ack`=1. Entry is refused while `ref_req` or `refresh_due` is 1.
- R10: Whenever `cke` is 0, `cmd_nop` is 1 and `ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Level request to stay in power-down |
| bank_open | input | NBANK | One bit per bank, 1 = row open |
| pre_issued | input | 1 | Pulse: a precharge was issued this cycle |
| trp_cycles | input | CW | Precharge time in clock cycles |
| refresh_due | input | 1 | Refresh timer has expired |
| ref_ack | input | 1 | Refresh engine accepted the request |
| cke | output | 1 | Clock enable to the device |
| cmd_nop | output | 1 | Command bus must carry NOP |
| ready | output | 1 | Command bus free for normal use |
| ref_req | output | 1 | Refresh request after a forced wake-up |

## Verification
The hardest case to reach from the ports is the dwell-limit wake-up. It needs the sleep request held with no refresh arriving for exactly MAX_DWELL cycles, and then it needs proof that the pending refresh request blocks an immediate re-entry. The vector table uses a small dwell limit and keeps `sleep_req` high row after row, so CKE must rise on one exact row and then stay high until `ref_ack` arrives. The precharge window is reached the same way: a `pre_issued` row followed by held sleep rows pins the falling edge to one exact cycle.

// File: rtl/sdram_pd_pkg.sv
package sdram_pd_pkg;
  typedef enum logic [2:0] {
    PD_AWAKE = 3'd0,
    PD_ENTER = 3'd1,
    PD_SLEEP = 3'd2,
    PD_WAKE1 = 3'd3,
    PD_WAKE2 = 3'd4
  } pd_state_e;
endpackage

// File: rtl/pd_trp_timer.sv
module pd_trp_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_issued,
  input  logic [CW-1:0] trp_cycles,
  output logic          trp_done
);
  logic [CW-1:0] remain;

  // Restarted by each precharge, counts down to zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remain <= '0;
    else if (pre_issued)       remain <= trp_cycles;
    else if (remain != '0)     remain <= remain - 1'b1;
  end

  // The last count cycle may already be the entry edge.
  assign trp_done = !pre_issued && (remain <= CW'(1));
endmodule

// File: rtl/pd_dwell_timer.sv
module pd_dwell_timer #(
  parameter int MAX_DWELL = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_phase,
  output logic expired
);
  localparam int DW = $clog2(MAX_DWELL + 1);
  localparam logic [DW-1:0] LIMIT = DW'(MAX_DWELL - 1);
  localparam logic [DW-1:0] TOP   = DW'(MAX_DWELL);

  logic [DW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (!low_phase) count <= '0;
    else if (count != TOP) count <= count + 1'b1;
  end

  assign expired = low_phase && (count >= LIMIT);
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
  import sdram_pd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_req,
  input  logic      entry_ok,
  input  logic      refresh_due,
  input  logic      dwell_exp,
  input  logic      ref_ack,
  output pd_state_e state,
  output logic      ref_req
);
  pd_state_e nxt;
  logic      forced;

  assign forced = (state == PD_SLEEP) && (refresh_due || dwell_exp);

  always_comb begin
    nxt = state;
    unique case (state)
      PD_AWAKE: if (sleep_req && entry_ok && !refresh_due && !ref_req) nxt = PD_ENTER;
      PD_ENTER: nxt = PD_SLEEP;
      PD_SLEEP: if (!sleep_req || forced) nxt = PD_WAKE1;
      PD_WAKE1: nxt = PD_WAKE2;
      PD_WAKE2: nxt = PD_AWAKE;
      default:  nxt = PD_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PD_AWAKE;
      ref_req <= 1'b0;
    end else begin
      state <= nxt;
      if (forced)       ref_req <= 1'b1;
      else if (ref_ack) ref_req <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_pd_ctrl.sv
module sdram_pd_ctrl
  import sdram_pd_pkg::*;
#(
  parameter int NBANK     = 4,
  parameter int CW        = 4,
  parameter int MAX_DWELL = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic [NBANK-1:0] bank_open,
  input  logic             pre_issued,
  input  logic [CW-1:0]    trp_cycles,
  input  logic             refresh_due,
  input  logic             ref_ack,
  output logic             cke,
  output logic             cmd_nop,
  output logic             ready,
  output logic             ref_req
);
  pd_state_e state;
  logic      trp_done;
  logic      dwell_exp;
  logic      low_phase;
  logic      entry_ok;

  pd_trp_timer #(.CW(CW)) u_trp (
    .clk(clk), .rst_n(rst_n), .pre_issued(pre_issued),
    .trp_cycles(trp_cycles), .trp_done(trp_done)
  );

  assign low_phase = (state == PD_ENTER) || (state == PD_SLEEP);

  pd_dwell_timer #(.MAX_DWELL(MAX_DWELL)) u_dwell (
    .clk(clk), .rst_n(rst_n), .low_phase(low_phase), .expired(dwell_exp)
  );

  assign entry_ok = (bank_open == '0) && trp_done;

  pd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .entry_ok(entry_ok),
    .refresh_due(refresh_due), .dwell_exp(dwell_exp), .ref_ack(ref_ack),
    .state(state), .ref_req(ref_req)
  );

  assign cke     = !low_phase;
  assign cmd_nop = (state != PD_AWAKE);
  assign ready   = (state == PD_AWAKE);
endmodule

// File: rtl/pd_ctrl_checker.sv
module pd_ctrl_checker #(
  parameter int NBANK     = 4,
  parameter int MAX_DWELL = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_req,
  input logic [NBANK-1:0] bank_open,
  input logic             pre_issued,
  input logic             refresh_due,
  input logic             ref_ack,
  input logic             cke,
  input logic             cmd_nop,
  input logic             ready,
  input logic             ref_req
);
  localparam int LW = $clog2(MAX_DWELL + 2) + 1;
  logic [LW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   low_run <= '0;
    else if (cke) low_run <= '0;
    else          low_run <= low_run + 1'b1;
  end

  a_r2_banks_closed: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(bank_open) == '0);
  a_r3_no_fresh_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> !$past(pre_issued));
  a_r4_entry_requested: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(sleep_req));
  a_r5_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |=> !cke);
  a_r6_exit_nop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> cmd_nop ##1 cmd_nop);
  a_r7_dwell_limit: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> low_run < LW'(MAX_DWELL));
  a_r8_refresh_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && $past(!cke) && refresh_due) |=> cke && ref_req);
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_ack) |=> ref_req);
  a_r9_no_entry_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> !$past(ref_req) && !$past(refresh_due));
  a_r10_nop_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> cmd_nop && !ready);
endmodule

bind sdram_pd_ctrl pd_ctrl_checker #(.NBANK(NBANK), .MAX_DWELL(MAX_DWELL)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .bank_open(bank_open),
  .pre_issued(pre_issued), .refresh_due(refresh_due), .ref_ack(ref_ack),
  .cke(cke), .cmd_nop(cmd_nop), .ready(ready), .ref_req(ref_req)
);

// File: tb/test_sdram_pd_ctrl.sv
`timescale 1ns/1ps
module test_sdram_pd_ctrl;
  localparam int NBANK = 4;
  localparam int CW = 4;
  localparam int MAXD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, pre_issued = 1'b0, refresh_due = 1'b0, ref_ack = 1'b0;
  logic [NBANK-1:0] bank_open = '0;
  logic [CW-1:0] trp_cycles = 4'd3;
  logic cke, cmd_nop, ready, ref_req;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sdram_pd_ctrl #(.NBANK(NBANK), .CW(CW), .MAX_DWELL(MAXD)) i_sdram_pd_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .bank_open(bank_open),
    .pre_issued(pre_issued), .trp_cycles(trp_cycles), .refresh_due(refresh_due),
    .ref_ack(ref_ack), .cke(cke), .cmd_nop(cmd_nop), .ready(ready), .ref_req(ref_req)
  );

  // {tag, bank_open, pre, sleep, rdue, ack, exp cke, nop, ready, ref_req}
  localparam logic [27:0] VEC [29] = '{
    {"R2", 4'b0001, 4'b0100, 4'b1010},
    {"R3", 4'b0000, 4'b1100, 4'b1010},
    {"R3", 4'b0000, 4'b0100, 4'b1010},
    {"R3", 4'b0000, 4'b0100, 4'b1010},
    {"R3", 4'b0000, 4'b0100, 4'b0100},
    {"R5", 4'b0000, 4'b0000, 4'b0100},
    {"R6", 4'b0000, 4'b0000, 4'b1100},
    {"R6", 4'b0000, 4'b0000, 4'b1100},
    {"R6", 4'b0000, 4'b0000, 4'b1010},
    {"R4", 4'b0000, 4'b0100, 4'b0100},
    {"R4", 4'b0000, 4'b0100, 4'b0100},
    {"R8", 4'b0000, 4'b0110, 4'b1101},
    {"R8", 4'b0000, 4'b0100, 4'b1101},
    {"R8", 4'b0000, 4'b0100, 4'b1011},
    {"R9", 4'b0000, 4'b0100, 4'b1011},
    {"R9", 4'b0000, 4'b0101, 4'b1010},
    {"R9", 4'b0000, 4'b0110, 4'b1010},
    {"R4", 4'b0000, 4'b0100, 4'b0100},
    {"R7", 4'b0000, 4'b0100, 4'b0100},
    {"R7", 4'b0000, 4'b0100, 4'b0100},
    {"R7", 4'b0000, 4'b0100, 4'b0100},
    {"R7", 4'b0000, 4'b0100, 4'b0100},
    {"R7", 4'b0000, 4'b0100, 4'b0100},
    {"R7", 4'b0000, 4'b0100, 4'b0100},
    {"R7", 4'b0000, 4'b0100, 4'b0100},
    {"R7", 4'b0000, 4'b0100, 4'b1101},
    {"R7", 4'b0000, 4'b0100, 4'b1101},
    {"R7", 4'b0000, 4'b0100, 4'b1011},
    {"R9", 4'b0000, 4'b0001, 4'b1010}
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {cke,nop,ready,ref_req} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [NBANK-1:0] b, input logic p, input logic s,
                      input logic r, input logic a);
    bank_open = b; pre_issued = p; sleep_req = s; refresh_due = r; ref_ack = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] outs();
    return {cke, cmd_nop, ready, ref_req};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(100_000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", outs(), 4'b1010);  // during reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", outs(), 4'b1010);

    for (int i = 0; i < 29; i++) begin
      step(VEC[i][11:8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
      check($sformatf("%s", VEC[i][27:12]), outs(), VEC[i][3:0]);
    end

    // R2: every single open bank blocks entry
    for (int b = 0; b < NBANK; b++) begin
      step(NBANK'(1) << b, 1'b0, 1'b1, 1'b0, 1'b0);
      step(NBANK'(1) << b, 1'b0, 1'b1, 1'b0, 1'b0);
      check("R2", outs(), 4'b1010);
    end

    // R3: zero precharge time enters right after the pulse edge
    trp_cycles = 4'd0;
    step('0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R3", outs(), 4'b1010);
    step('0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R3", outs(), 4'b0100);
    step('0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R10", outs(), 4'b0100);

    // R1: asynchronous reset while powered down
    #2 rst_n = 1'b0;
    #1 check("R1", outs(), 4'b1010);
    @(negedge clk);
    rst_n = 1'b1;
    sleep_req = 1'b0;
    @(negedge clk);
    check("R1", outs(), 4'b1010);

    finish_run();
  end
endmodule